// File: doc/BRIEF.md
# Variable-Length Bit Field Packer

The packer merges two variable-length bit fields per accepted cycle into a continuous LSB-first bit stream and cuts that stream into 32-bit words for a downstream FIFO. The first field carries 1 to 16 valid bits and the second carries 1 to 12. Both are appended above whatever bits earlier cycles left behind. Each field is placed at its bit offset by multiplying it with a one-hot power of two rather than by a wide shift multiplexer. The placed fields are then ORed into a 64-bit accumulator.

When the accumulator holds 32 or more bits, the low 32 go out as a word and the rest move down to bit 0. A flush request sends out a partly filled final word with zero upper bits. A full FIFO stalls the block: the pending word is held and no new input is taken until the FIFO takes the word.

Top module: `bitPacker`

## Requirements
- R1: After reset, `outPush` is 0, `inReady` is 1 and the packer holds no bits.
- R2: Bits are packed LSB-first. Within one input cycle, `fieldA` occupies the lower positions and `fieldB` sits directly above it. Bits left from earlier cycles sit below both, and word bit 0 is the oldest bit.
- R3: Only bits 0 to len-1 of each field are used. Higher input bits never appear in any output word.
- R4: When an accepted input brings the stored count to 32 or more, `outPush` rises in the cycle after the accepting edge, carrying the low 32 bits. The remaining bits carry over to the next word.
- R5: An accepted input that leaves fewer than 32 bits stored produces no push.
- R6: `flush` with `inValid` low and a nonzero bit count emits the stored bits as one word, zero above the stored count, in the cycle after the edge. Packing then restarts at bit 0.
- R7: `flush` with no stored bits produces no push.
- R8: `flush` asserted together with `inValid` has no effect. The fields are packed and the stored bits remain.
- R9: While `outPush` is high and `fifoFull` is high, `inReady` is low and `outPush` and `outWord` hold their values.
- R10: The stored bit count stays below 32 between cycles, and accumulator bits at or above that count are zero.
- R11: A word that the FIFO takes (`outPush` high, `fifoFull` low) is pushed only once. With no new input or flush, `outPush` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Fields and lengths are valid this cycle |
| inReady | output | 1 | Block takes input or flush this cycle |
| fieldA | input | 16 | First field, low `lenA` bits valid |
| lenA | input | 5 | Length of first field, 1 to 16 |
| fieldB | input | 12 | Second field, low `lenB` bits valid |
| lenB | input | 4 | Length of second field, 1 to 12 |
| flush | input | 1 | Emit the partial word (honoured only with `inValid` low) |
| outWord | output | 32 | Word for the FIFO |
| outPush | output | 1 | Word on `outWord` is offered to the FIFO |
| fifoFull | input | 1 | FIFO cannot take a word this cycle |

## Verification
Every accepted input or flush acts at one rising edge. The matching word shows on `outWord` with `outPush` high in the very next cycle and stays there for as long as `fifoFull` holds it. The driver puts stimulus on the falling edge and, after each acceptance, moves to the next falling edge to check `outPush` against the push that a bit-level queue model predicts. A monitor samples one nanosecond after each falling edge and compares every word the FIFO takes against the model's queue in order. A stall, meaning a full FIFO, is checked over several held cycles before it is released.

// File: rtl/packPkg.sv
package packPkg;
  typedef struct packed {
    logic loadIn;    // take fields into accumulator
    logic emitFull;  // accumulated word is complete: cut 32 bits
    logic flushOut;  // emit partial word and clear
  } packCtrl_t;
endpackage

// File: rtl/packDatapath.sv
module packDatapath
  import packPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int A_W    = 16,
  parameter int B_W    = 12,
  parameter int ACC_W  = 64,
  localparam int LA_W  = $clog2(A_W + 1),
  localparam int LB_W  = $clog2(B_W + 1),
  localparam int CNT_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [A_W-1:0]    fieldA,
  input  logic [LA_W-1:0]   lenA,
  input  logic [B_W-1:0]    fieldB,
  input  logic [LB_W-1:0]   lenB,
  input  packCtrl_t         ctrl,
  output logic [CNT_W-1:0]  fillNow,
  output logic [CNT_W-1:0]  fillNext,
  output logic [WORD_W-1:0] outWord
);
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  fill;
  logic [LA_W-1:0]   effA;
  logic [LB_W-1:0]   effB;
  logic [A_W-1:0]    maskedA;
  logic [B_W-1:0]    maskedB;
  logic [CNT_W-1:0]  posB;
  logic [ACC_W-1:0]  pow2A, pow2B;
  logic [ACC_W-1:0]  prodA, prodB, merged, shiftedDown;

  // clamp lengths to the field width
  assign effA = (lenA > LA_W'(A_W)) ? LA_W'(A_W) : lenA;
  assign effB = (lenB > LB_W'(B_W)) ? LB_W'(B_W) : lenB;

  // keep only the low length bits of each field
  for (genvar i = 0; i < A_W; i++) begin : g_maskA
    assign maskedA[i] = fieldA[i] & (LA_W'(i) < effA);
  end
  for (genvar j = 0; j < B_W; j++) begin : g_maskB
    assign maskedB[j] = fieldB[j] & (LB_W'(j) < effB);
  end

  assign posB     = fill + CNT_W'(effA);
  assign fillNext = posB + CNT_W'(effB);
  assign fillNow  = fill;

  // one-hot power-of-two multiplicands
  for (genvar k = 0; k < ACC_W; k++) begin : g_pow2
    assign pow2A[k] = (fill == CNT_W'(k));
    assign pow2B[k] = (posB == CNT_W'(k));
  end

  // placement by multiplication, then OR into residue
  assign prodA       = ACC_W'(maskedA) * pow2A;
  assign prodB       = ACC_W'(maskedB) * pow2B;
  assign merged      = acc | prodA | prodB;
  assign shiftedDown = merged >> WORD_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      fill    <= '0;
      outWord <= '0;
    end else if (ctrl.loadIn) begin
      if (ctrl.emitFull) begin
        outWord <= merged[WORD_W-1:0];
        acc     <= shiftedDown;
        fill    <= fillNext - CNT_W'(WORD_W);
      end else begin
        acc     <= merged;
        fill    <= fillNext;
      end
    end else if (ctrl.flushOut) begin
      outWord <= acc[WORD_W-1:0];
      acc     <= '0;
      fill    <= '0;
    end
  end

  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    fill < CNT_W'(WORD_W));

  assert_clean_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acc >> fill) == '0);

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flushOut |=> (fill == '0));
endmodule

// File: rtl/packControl.sv
module packControl
  import packPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             flush,
  input  logic             fifoFull,
  input  logic [CNT_W-1:0] fillNow,
  input  logic [CNT_W-1:0] fillNext,
  output logic             inReady,
  output logic             outPush,
  output packCtrl_t        ctrl
);
  logic pendValid;

  assign inReady       = !pendValid || !fifoFull;
  assign ctrl.loadIn   = inValid && inReady;
  assign ctrl.emitFull = ctrl.loadIn && (fillNext >= CNT_W'(WORD_W));
  assign ctrl.flushOut = flush && !inValid && inReady && (fillNow != '0);
  assign outPush       = pendValid;

  always_ff @(posedge clk) begin
    if (!rstN)        pendValid <= 1'b0;
    else if (inReady) pendValid <= ctrl.emitFull || ctrl.flushOut;
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && fifoFull) |=> outPush);

  assert_single_push_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && !fifoFull && !inValid && !flush) |=> !outPush);

  assert_exclusive_strobes_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadIn && ctrl.flushOut));
endmodule

// File: rtl/bitPacker.sv
module bitPacker
  import packPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int A_W    = 16,
  parameter int B_W    = 12,
  parameter int ACC_W  = 64,
  localparam int LA_W  = $clog2(A_W + 1),
  localparam int LB_W  = $clog2(B_W + 1),
  localparam int CNT_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [A_W-1:0]    fieldA,
  input  logic [LA_W-1:0]   lenA,
  input  logic [B_W-1:0]    fieldB,
  input  logic [LB_W-1:0]   lenB,
  input  logic              flush,
  output logic [WORD_W-1:0] outWord,
  output logic              outPush,
  input  logic              fifoFull
);
  packCtrl_t        ctrl;
  logic [CNT_W-1:0] fillNow, fillNext;

  packControl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flush(flush),
    .fifoFull(fifoFull), .fillNow(fillNow), .fillNext(fillNext),
    .inReady(inReady), .outPush(outPush), .ctrl(ctrl)
  );

  packDatapath #(.WORD_W(WORD_W), .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .fieldA(fieldA), .lenA(lenA),
    .fieldB(fieldB), .lenB(lenB), .ctrl(ctrl),
    .fillNow(fillNow), .fillNext(fillNext), .outWord(outWord)
  );

  assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && fifoFull) |=> $stable(outWord));

  assert_no_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && fifoFull) |-> !inReady);
endmodule

// File: tb/bitPacker_tb.sv
module bitPacker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] fieldA = '0;
  logic [4:0]  lenA = 5'd1;
  logic [11:0] fieldB = '0;
  logic [3:0]  lenB = 4'd1;
  logic        flush = 1'b0;
  logic [31:0] outWord;
  logic        outPush;
  logic        fifoFull = 1'b0;

  int errors = 0;
  int checks = 0;
  bit mq[$];
  logic [31:0] expQ[$];
  bit finished = 0;

  always #2 clk = ~clk;

  bitPacker u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .fieldA(fieldA), .lenA(lenA), .fieldB(fieldB), .lenB(lenB),
    .flush(flush), .outWord(outWord), .outPush(outPush), .fifoFull(fifoFull)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply one field pair, update model, check push strobe
  task automatic send(input logic [15:0] a, input int la, input logic [11:0] b, input int lb,
                      input bit withFlush, input bit full);
    bit willPush = 0;
    logic [31:0] w;
    fifoFull = full;
    fieldA = a; lenA = 5'(la); fieldB = b; lenB = 4'(lb);
    inValid = 1'b1; flush = withFlush;
    #1;
    while (!inReady) begin @(negedge clk); fifoFull = 1'b0; #1; end
    for (int i = 0; i < la; i++) mq.push_back(a[i]);
    for (int i = 0; i < lb; i++) mq.push_back(b[i]);
    if (mq.size() >= 32) begin
      for (int i = 0; i < 32; i++) w[i] = mq.pop_front();
      expQ.push_back(w);
      willPush = 1;
    end
    @(negedge clk);
    inValid = 1'b0; flush = 1'b0;
    chk(outPush == willPush, willPush ? "R4 push due" : "R5 no push", 32'(outPush), 32'(willPush));
  endtask

  task automatic doFlush();
    bit willPush = 0;
    logic [31:0] w = '0;
    flush = 1'b1;
    #1;
    while (!inReady) begin @(negedge clk); fifoFull = 1'b0; #1; end
    if (mq.size() > 0) begin
      for (int i = 0; i < 32; i++) w[i] = (mq.size() > 0) ? mq.pop_front() : 1'b0;
      expQ.push_back(w);
      willPush = 1;
    end
    @(negedge clk);
    flush = 1'b0;
    chk(outPush == willPush, willPush ? "R6 flush push" : "R7 empty flush", 32'(outPush), 32'(willPush));
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rstN && outPush && !fifoFull) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected word", outWord, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(outWord == e, "R2 word content", outWord, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(outPush == 1'b0, "R1 reset push", 32'(outPush), 32'h0);
    chk(inReady == 1'b1, "R1 reset ready", 32'(inReady), 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    // R5: small fill, no push
    send(16'h0003, 2, 12'h005, 3, 0, 0);
    // R2: ordering, max lengths to complete a word
    send(16'hA5C3, 16, 12'h9E1, 12, 0, 0);
    send(16'h1234, 16, 12'hFED, 12, 0, 0);
    // R3: garbage above lengths
    send(16'hFFFF, 4, 12'hFFF, 2, 0, 0);
    send(16'hFFF0, 1, 12'hFFE, 1, 0, 0);
    // R6: flush partial, then restart at bit 0
    doFlush();
    @(negedge clk);
    chk(outPush == 1'b0, "R11 single push", 32'(outPush), 32'h0);
    // R7: flush with empty packer
    doFlush();
    send(16'h00B7, 8, 12'h03C, 6, 0, 0);
    // R8: flush alongside valid is ignored
    send(16'h0F0F, 16, 12'h0AA, 8, 1, 0);
    doFlush();
    @(negedge clk);
    // R9: stall with full FIFO
    send(16'hBEEF, 16, 12'hCAF, 12, 0, 1);
    send(16'h1357, 16, 12'h246, 12, 0, 1);
    held = outWord;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(outPush == 1'b1, "R9 push held", 32'(outPush), 32'h1);
      chk(inReady == 1'b0, "R9 ready low", 32'(inReady), 32'h0);
      chk(outWord == held, "R9 word held", outWord, held);
    end
    @(negedge clk);
    fifoFull = 1'b0;
    @(negedge clk); #1;
    chk(outPush == 1'b0, "R11 single push after stall", 32'(outPush), 32'h0);
    @(negedge clk);

    // random traffic
    void'($urandom(7));
    for (int n = 0; n < 600; n++) begin
      int la, lb;
      la = 1 + ($urandom % 16);
      lb = 1 + ($urandom % 12);
      send(16'($urandom), la, 12'($urandom), lb, ($urandom % 7) == 0, ($urandom % 4) == 0);
      if (($urandom % 25) == 0) doFlush();
    end
    fifoFull = 1'b0;
    doFlush();
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R4 all words delivered", 32'(expQ.size()), 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule